// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two unsigned operands and a carry-in without waiting for carries to pass from bit to bit. Each bit forms a generate term (both operand bits set) and a propagate term (either operand bit set). The bits are gathered into 4-bit groups. Each group works out its three inner carries as flat sum-of-products expressions of its own generate and propagate terms and its group carry-in. Each group also reports a group generate and a group propagate.

A second lookahead stage takes those group terms and forms the carry into every group of a 16-bit section in the same flat way. The carry out of the top group is the carry-out of the section. Widths beyond 16 are built from 16-bit sections: each section takes the previous section's carry-out as its carry-in. The block is purely combinational.

Top module: `cla_adder`

## Requirements
- R1: For every input, the concatenation {carry_out, sum} equals a + b + carry_in as an unsigned sum that is W+1 bits wide.
- R2: carry_out is 1 exactly when a + b + carry_in is 2^W or more.
- R3: When a 4-bit group's generate term is set (a carry would leave the group even with carry-in 0), a carry leaves that group whatever its carry-in is.
- R4: When a group has neither its generate term nor its propagate term (propagate = every bit has at least one operand bit set), no carry leaves that group.
- R5: When a group has its propagate term but not its generate term, the carry leaving the group equals the carry entering it.
- R6: Every bit carry equals the majority of that bit's a, b and incoming carry.
- R7: All ones plus zero with carry-in 1, and all ones plus 1 with carry-in 0, both give sum 0 and carry_out 1.
- R8: Alternating patterns (0xAAAA.. with 0x5555..) give all ones with carry_out 0 when carry-in is 0, and sum 0 with carry_out 1 when carry-in is 1.
- R9: W must be a multiple of 16. At W = 32 the two 16-bit sections chain, and R1 holds across the section boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | W | Low W bits of the total |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
Two things happen together when an addition is evaluated. The second lookahead stage predicts the carry into each group, and each group expands its own inner carries from that predicted value. A wrong group carry therefore shows up only in the sum bits of the group above it. The bench provokes both at once. It sweeps every low-byte operand pair while the upper bits are set so that any carry must pass through the upper groups, and it adds patterns that make a chosen group generate, kill or pass a carry. Each result is judged against the arithmetic total computed in the bench, at 16 bits and at 32 bits.

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         carry_in,
  output logic [W-1:0] sum,
  output logic         carry_out
);
  localparam int NG = W / 4;
  localparam int NS = W / 16;

  logic [W-1:0]  g, p;
  logic [W:0]    c;
  logic [NG-1:0] gg, gp;
  logic [NG:0]   gcv;

  assign g = a & b;
  assign p = a | b;
  assign gcv[0] = carry_in;

  for (genvar k = 0; k < NG; k++) begin : grp
    localparam int I = 4 * k;
    assign c[I]   = gcv[k];
    assign c[I+1] = g[I] | (p[I] & gcv[k]);
    assign c[I+2] = g[I+1] | (p[I+1] & g[I]) | (p[I+1] & p[I] & gcv[k]);
    assign c[I+3] = g[I+2] | (p[I+2] & g[I+1]) | (p[I+2] & p[I+1] & g[I])
                  | (p[I+2] & p[I+1] & p[I] & gcv[k]);
    assign gg[k]  = g[I+3] | (p[I+3] & g[I+2]) | (p[I+3] & p[I+2] & g[I+1])
                  | (p[I+3] & p[I+2] & p[I+1] & g[I]);
    assign gp[k]  = &p[I+3:I];
  end

  for (genvar s = 0; s < NS; s++) begin : sec
    localparam int J = 4 * s;
    logic sx;
    if (s == 0) begin : first
      assign sx = carry_in;
    end else begin : chained
      assign sx = gcv[J];
    end
    assign gcv[J+1] = gg[J] | (gp[J] & sx);
    assign gcv[J+2] = gg[J+1] | (gp[J+1] & gg[J]) | (gp[J+1] & gp[J] & sx);
    assign gcv[J+3] = gg[J+2] | (gp[J+2] & gg[J+1]) | (gp[J+2] & gp[J+1] & gg[J])
                    | (gp[J+2] & gp[J+1] & gp[J] & sx);
    assign gcv[J+4] = gg[J+3] | (gp[J+3] & gg[J+2]) | (gp[J+3] & gp[J+2] & gg[J+1])
                    | (gp[J+3] & gp[J+2] & gp[J+1] & gg[J])
                    | (&gp[J+3:J] & sx);
  end

  assign c[W]      = gcv[NG];
  assign carry_out = gcv[NG];
  assign sum       = a ^ b ^ c[W-1:0];

  always_comb begin
    assert_total_R1: assert ({carry_out, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, carry_in}))
      else $error("R1 total mismatch");
    for (int k = 0; k < NG; k++) begin
      if (gg[k]) begin
        assert_group_gen_R3: assert (gcv[k+1]) else $error("R3 group %0d", k);
      end
      if (!gg[k] && !gp[k]) begin
        assert_group_kill_R4: assert (!gcv[k+1]) else $error("R4 group %0d", k);
      end
      if (!gg[k] && gp[k]) begin
        assert_group_pass_R5: assert (gcv[k+1] == gcv[k]) else $error("R5 group %0d", k);
      end
    end
    for (int i = 0; i < W; i++) begin
      assert_bit_carry_R6: assert (c[i+1] == ((a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i])))
        else $error("R6 bit %0d", i);
    end
  end
endmodule

// File: tb/cla_adder_test.sv
module cla_adder_test;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int W2 = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [W-1:0]  a, b, s;
  logic          ci, co;
  logic [W2-1:0] a2, b2, s2;
  logic          ci2, co2;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  cla_adder #(.W(W)) uut (.a(a), .b(b), .carry_in(ci), .sum(s), .carry_out(co));
  cla_adder #(.W(W2)) uut32 (.a(a2), .b(b2), .carry_in(ci2), .sum(s2), .carry_out(co2));

  task automatic chk(input string tag, input logic [W2:0] act, input logic [W2:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run16(input string tag, input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic cin);
    logic [W:0] exp;
    @(posedge clk);
    a = x; b = y; ci = cin;
    exp = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    @(negedge clk);
    chk(tag, {{(W2-W){1'b0}}, co, s}, {{(W2-W){1'b0}}, exp});
  endtask

  task automatic run32(input string tag, input logic [W2-1:0] x, input logic [W2-1:0] y,
                       input logic cin);
    logic [W2:0] exp;
    @(posedge clk);
    a2 = x; b2 = y; ci2 = cin;
    exp = {1'b0, x} + {1'b0, y} + {{W2{1'b0}}, cin};
    @(negedge clk);
    chk(tag, {co2, s2}, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; ci = 1'b0;
    a2 = '0; b2 = '0; ci2 = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset zero", {{(W2-W){1'b0}}, co, s}, '0);
    rst_n = 1'b1;

    // R7 full carry across all groups
    run16("R7 ones plus cin", 16'hFFFF, 16'h0000, 1'b1);
    run16("R7 ones plus one", 16'hFFFF, 16'h0001, 1'b0);
    run16("R2 ones plus ones", 16'hFFFF, 16'hFFFF, 1'b1);
    // R8 alternating bits
    run16("R8 alt cin0", 16'hAAAA, 16'h5555, 1'b0);
    run16("R8 alt cin1", 16'hAAAA, 16'h5555, 1'b1);
    run16("R8 alt same", 16'hAAAA, 16'hAAAA, 1'b1);
    // R3 group 1 generates, R4 group 2 kills, R5 upper groups pass
    run16("R3 generate in group1", 16'hF0F0, 16'h0010, 1'b0);
    run16("R4 kill in group2", 16'hF0FF, 16'h0001, 1'b0);
    run16("R5 pass to carry_out", 16'hFFF0, 16'h0010, 1'b0);
    run16("R2 no carry", 16'h7FFF, 16'h0000, 1'b1);

    for (int i = 0; i < 16; i++) begin
      run16("R6 walking bit", 16'(1 << i), 16'(1 << i), i[0]);
    end

    // near-exhaustive low-byte sweep, upper bits propagate (R1, R6)
    for (int i = 0; i < 65536; i++) begin
      run16("R1 sweep", {8'hFF, i[7:0]}, {8'h00, i[15:8]}, ^i[3:0]);
    end
    for (int i = 0; i < 3000; i++) begin
      run16("R1 random", 16'($urandom), 16'($urandom), 1'($urandom));
    end

    // R9 two chained sections
    run32("R9 wide full carry", 32'hFFFF_FFFF, 32'h0, 1'b1);
    run32("R9 section boundary", 32'h0000_FFFF, 32'h0000_0001, 1'b0);
    run32("R9 alt", 32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
    for (int i = 0; i < 3000; i++) begin
      run32("R9 random", $urandom, $urandom, 1'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule